// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block is the data memory of a small 8-bit controller. It holds sixteen global registers and sixteen banks of sixteen registers each. A 5-bit register field taken from the instruction picks a location, and the block resolves that field to a physical entry in one of three ways.

Low fields select a global register. High fields combine the upper nibble of a pointer register with the low bits of the field. Field zero uses the whole pointer as an address. The pointer register is global slot 04h, so ordinary register writes update it.

A separate bank operation rewrites only the three bank bits of the pointer. It cannot move between the lower block of banks (00h–7Fh) and the upper block (80h–FFh); only the top pointer bit does that. Writes take effect on the rising clock edge. Reads are combinational from the field and the current pointer.

Top module: `banked_regfile_map`

## Requirements
- R1: After reset the pointer reads 00h. When CLEAR_ON_RESET is 1, every storage location also reads 00h after reset.
- R2: Fields 01h–0Fh reach global registers 01h–0Fh, whatever value the pointer holds.
- R3: Global slot 04h is the pointer. A direct write to field 04h sets the pointer to the written byte, and reading field 04h returns the pointer.
- R4: Fields 10h–1Fh reach banked location {pointer[7:4], field[3:0]}. With the pointer at 00h, bank 0 is reached.
- R5: A bank operation copies immediate bits 6:4 into pointer bits 6:4. Pointer bit 7 and bits 3:0 keep their values, and immediate bits 7 and 3:0 have no effect.
- R6: Pointer bit 7 picks the upper block (banks 8–F) when set and the lower block (banks 0–7) when clear. Setting it with a direct write after a bank operation moves semi-direct accesses into the upper block.
- R7: Field 00h with a pointer of 10h–FFh accesses banked location equal to the pointer (for example F5h is bank F, row 5).
- R8: Field 00h with a pointer of 01h–0Fh accesses the global register of that number, including the pointer itself at 04h. No indirect access reaches bank 0.
- R9: Field 00h with the pointer at 00h reads 00h, and a write to it changes no location.
- R10: A write becomes visible on reads only after the next rising clock edge. The read value before that edge is the old value.
- R11: When a bank operation and a direct write of the pointer fall in the same cycle, the new pointer takes bit 7 and bits 3:0 from the written byte and bits 6:4 from the immediate.
- R12: A loop runs from pointer 00h until the pointer wraps to 00h. Each pass sets pointer bit 3, clears through field 00h, then increments the pointer. After the loop, rows 8–F of the global bank and of banks 1–F read 00h, and every other location keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_fld | input | 5 | Register field from the instruction |
| wr_en | input | 1 | Write strobe for the addressed location |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Combinational read of the addressed location |
| bank_sel | input | 1 | Bank operation strobe |
| bank_imm | input | 8 | Bank operation immediate; only bits 6:4 are used |

## Verification
A bank operation and a write to the pointer can fall in the same clock edge. So can an indirect write whose target is the pointer itself (pointer 04h, field 00h). The bench provokes both on purpose: a directed cycle raises bank_sel together with a field-04h write, and a random phase mixes strobes freely. Every cycle it compares the read data with a behavioural model that applies the write first and then merges the immediate bits. The next read of field 04h must show that merged byte.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_GLB  = 2'd1,
        TGT_BNK  = 2'd2
    } tgt_e;
endpackage

// File: rtl/bfm_resolve.sv
module bfm_resolve
    import bfm_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int BANK_W = 4,
    localparam int AW    = ROW_W + BANK_W
) (
    input  logic [ROW_W:0]   fld,
    input  logic [AW-1:0]    ptr,
    output tgt_e             kind,
    output logic [ROW_W-1:0] gidx,
    output logic [AW-1:0]    baddr
);
    always_comb begin
        kind  = TGT_NONE;
        gidx  = fld[ROW_W-1:0];
        baddr = {ptr[AW-1:ROW_W], fld[ROW_W-1:0]};
        if (fld[ROW_W]) begin
            kind = TGT_BNK;
        end else if (fld[ROW_W-1:0] != '0) begin
            kind = TGT_GLB;
        end else if (ptr == '0) begin
            kind = TGT_NONE;
        end else if (ptr[AW-1:ROW_W] == '0) begin
            kind = TGT_GLB;
            gidx = ptr[ROW_W-1:0];
        end else begin
            kind  = TGT_BNK;
            baddr = ptr;
        end
    end
endmodule

// File: rtl/bfm_bankreg.sv
module bfm_bankreg #(
    parameter int DW     = 8,
    parameter int ROW_W  = 4,
    parameter int BANK_W = 4,
    localparam int AW    = ROW_W + BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          bop,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] ptr_q
);
    typedef struct packed {
        logic [DW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.ptr = wdata;
        if (bop) st_d.ptr[AW-2:ROW_W] = imm[AW-2:ROW_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q = st_q.ptr;

    // R3
    ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !bop) |=> (ptr_q == $past(wdata)));

    // R5
    bank_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop && !we) |=> (ptr_q[AW-1] == $past(ptr_q[AW-1])
                       && ptr_q[ROW_W-1:0] == $past(ptr_q[ROW_W-1:0])
                       && ptr_q[AW-2:ROW_W] == $past(imm[AW-2:ROW_W])));

    // R11
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop && we) |=> (ptr_q[AW-1] == $past(wdata[AW-1])
                      && ptr_q[ROW_W-1:0] == $past(wdata[ROW_W-1:0])
                      && ptr_q[AW-2:ROW_W] == $past(imm[AW-2:ROW_W])));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !bop) |=> $stable(ptr_q));
endmodule

// File: rtl/bfm_store.sv
module bfm_store #(
    parameter int DW      = 8,
    parameter int ROW_W   = 4,
    parameter int AW      = 8,
    parameter bit CLR     = 1'b0,
    localparam int GDEPTH = 1 << ROW_W,
    localparam int BDEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             g_we,
    input  logic [ROW_W-1:0] g_idx,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    g_rdata,
    output logic [DW-1:0]    b_rdata
);
    logic [DW-1:0] gmem_q [GDEPTH];
    logic [DW-1:0] bmem_q [BDEPTH];

    generate
        if (CLR) begin : g_clr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < GDEPTH; i++) gmem_q[i] <= '0;
                    for (int j = 0; j < BDEPTH; j++) bmem_q[j] <= '0;
                end else begin
                    if (g_we) gmem_q[g_idx]  <= wdata;
                    if (b_we) bmem_q[b_addr] <= wdata;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (g_we) gmem_q[g_idx]  <= wdata;
                if (b_we) bmem_q[b_addr] <= wdata;
            end
        end
    endgenerate

    assign g_rdata = gmem_q[g_idx];
    assign b_rdata = bmem_q[b_addr];

    // R10
    no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(g_we && b_we));
endmodule

// File: rtl/banked_regfile_map.sv
module banked_regfile_map
    import bfm_pkg::*;
#(
    parameter int DW             = 8,
    parameter int ROW_W          = 4,
    parameter int BANK_W         = 4,
    parameter int PTR_SLOT       = 4,
    parameter bit CLEAR_ON_RESET = 1'b0,
    localparam int AW            = ROW_W + BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [ROW_W:0] reg_fld,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          bank_sel,
    input  logic [DW-1:0] bank_imm
);
    tgt_e             kind;
    logic [ROW_W-1:0] gidx;
    logic [AW-1:0]    baddr;
    logic [DW-1:0]    ptr_q;
    logic [DW-1:0]    g_rdata, b_rdata;
    logic             hit_ptr, ptr_we, g_we, b_we;

    bfm_resolve #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_resolve (
        .fld   (reg_fld),
        .ptr   (ptr_q[AW-1:0]),
        .kind  (kind),
        .gidx  (gidx),
        .baddr (baddr)
    );

    assign hit_ptr = (kind == TGT_GLB) && (gidx == ROW_W'(PTR_SLOT));
    assign ptr_we  = wr_en && hit_ptr;
    assign g_we    = wr_en && (kind == TGT_GLB) && !hit_ptr;
    assign b_we    = wr_en && (kind == TGT_BNK);

    bfm_bankreg #(.DW(DW), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_bankreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ptr_we),
        .wdata (wr_data),
        .bop   (bank_sel),
        .imm   (bank_imm),
        .ptr_q (ptr_q)
    );

    bfm_store #(.DW(DW), .ROW_W(ROW_W), .AW(AW), .CLR(CLEAR_ON_RESET)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .g_we    (g_we),
        .g_idx   (gidx),
        .b_we    (b_we),
        .b_addr  (baddr),
        .wdata   (wr_data),
        .g_rdata (g_rdata),
        .b_rdata (b_rdata)
    );

    always_comb begin
        case (kind)
            TGT_GLB:  rd_data = hit_ptr ? ptr_q : g_rdata;
            TGT_BNK:  rd_data = b_rdata;
            default:  rd_data = '0;
        endcase
    end

    // R10
    onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_we, g_we, b_we}));

    // R9
    null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_fld == '0 && ptr_q == '0) |-> (rd_data == '0 && !g_we && !b_we && !ptr_we));

    // R8
    no_bank0_indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_fld == '0 && kind == TGT_BNK) |-> (baddr[AW-1:ROW_W] != '0));

    // R2
    direct_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_fld[ROW_W] && reg_fld[ROW_W-1:0] != '0) |-> (kind == TGT_GLB && gidx == reg_fld[ROW_W-1:0]));
endmodule

// File: tb/tb_banked_regfile_map.sv
module tb_banked_regfile_map;
    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_fld = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       bank_sel = 1'b0;
    logic [7:0] bank_imm = '0;

    int n_chk = 0;
    int n_fail = 0;
    int last_rd = 0;
    int gm [16];
    int bm [256];
    int mptr = 0;

    always #(CYC/2) clk = ~clk;

    banked_regfile_map #(.CLEAR_ON_RESET(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_fld(reg_fld), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .bank_sel(bank_sel), .bank_imm(bank_imm)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // model target: -1 none, 1000+g global, else banked address
    function automatic int tgt(input int f);
        if (f >= 16) return (mptr & 'hF0) | (f & 15);
        if (f != 0) return 1000 + f;
        if (mptr == 0) return -1;
        if (mptr < 16) return 1000 + mptr;
        return mptr;
    endfunction

    function automatic int mread(input int f);
        int t = tgt(f);
        if (t < 0) return 0;
        if (t == 1004) return mptr;
        if (t >= 1000) return gm[t-1000];
        return bm[t];
    endfunction

    task automatic step(input int f, input bit we, input int wd, input bit bop,
                        input int imm, input string tag);
        int t;
        @(negedge clk);
        reg_fld = 5'(f); wr_en = we; wr_data = 8'(wd); bank_sel = bop; bank_imm = 8'(imm);
        #1;
        last_rd = int'(rd_data);
        chk(last_rd, mread(f), tag);
        @(posedge clk);
        t = tgt(f);
        if (we) begin
            if (t == 1004) mptr = wd & 255;
            else if (t >= 1000) gm[t-1000] = wd & 255;
            else if (t >= 0) bm[t] = wd & 255;
        end
        if (bop) mptr = (mptr & 'h8F) | (imm & 'h70);
    endtask

    task automatic wr(input int f, input int v, input string tag);
        step(f, 1'b1, v, 1'b0, 0, tag);
    endtask

    task automatic rd(input int f, input string tag);
        step(f, 1'b0, 0, 1'b0, 0, tag);
    endtask

    function automatic int pat(input int a);
        return ((a * 37 + 11) & 255) | 1;
    endfunction

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CYC * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int v;
        foreach (gm[i]) gm[i] = 0;
        foreach (bm[i]) bm[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4, "R1");  chk(last_rd, 0, "R1");
        rd('h15, "R1"); chk(last_rd, 0, "R1");

        // R2 / R10 direct globals; write seen only after the edge
        wr(1, 'h11, "R10"); chk(last_rd, 0, "R10");
        rd(1, "R2"); chk(last_rd, 'h11, "R2");
        wr(4, 'h30, "R3");
        wr('h0F, 'hA5, "R2");
        rd('h0F, "R2"); chk(last_rd, 'hA5, "R2");
        rd(4, "R3"); chk(last_rd, 'h30, "R3");

        // R4 semi-direct
        wr(4, 'hF0, "R3");
        wr('h1F, 'h5A, "R4");
        wr(4, 'h00, "R3");
        wr('h1F, 'h66, "R4");
        rd('h1F, "R4"); chk(last_rd, 'h66, "R4");
        wr(4, 'hF5, "R3");
        rd(0, "R7"); chk(last_rd, 0, "R7");
        wr(4, 'hFF, "R3");
        rd(0, "R7"); chk(last_rd, 'h5A, "R7");

        // R5 bank op keeps block and low bits
        wr(4, 'h0C, "R3");
        step(0, 1'b0, 0, 1'b1, 'hA3, "R5");
        rd(4, "R5"); chk(last_rd, 'h2C, "R5");
        step(0, 1'b0, 0, 1'b1, 'h80, "R5");
        rd(4, "R5"); chk(last_rd, 'h0C, "R5");

        // R6 set bit 7 after bank op
        step(0, 1'b0, 0, 1'b1, 'h30, "R6");
        rd(4, "R6"); v = last_rd;
        wr(4, v | 'h80, "R6");
        wr('h12, 'h77, "R6");
        wr(4, 'hB2, "R6");
        rd(0, "R6"); chk(last_rd, 'h77, "R6");
        wr(4, 'h32, "R6");
        rd(0, "R6"); chk(last_rd, 0, "R6");

        // R7 indirect write F5
        wr(4, 'hF5, "R7");
        wr(0, 'h01, "R7");
        wr(4, 'hF0, "R7");
        rd('h15, "R7"); chk(last_rd, 'h01, "R7");

        // R8 indirect to global and to the pointer itself
        wr(4, 'h01, "R8");
        rd(0, "R8"); chk(last_rd, 'h11, "R8");
        wr(4, 'h04, "R8");
        wr(0, 'h9E, "R8");
        rd(4, "R8"); chk(last_rd, 'h9E, "R8");

        // R9 null pointer
        wr(4, 'h00, "R9");
        wr(0, 'hEE, "R9");
        rd(0, "R9"); chk(last_rd, 0, "R9");
        rd('h10, "R9"); chk(last_rd, 0, "R9");

        // R11 bank op and pointer write together
        step(4, 1'b1, 'h8A, 1'b1, 'h35, "R11");
        rd(4, "R11"); chk(last_rd, 'hBA, "R11");

        // random mix, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            step(int'($urandom_range(0, 31)), 1'($urandom), int'($urandom_range(0, 255)),
                 ($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)), "R11");
        end

        // R12 fill every location, then run the clearing loop
        for (int g = 1; g < 16; g++) if (g != 4) wr(g, pat(g), "R12");
        for (int b = 0; b < 16; b++) begin
            wr(4, b << 4, "R12");
            for (int r = 0; r < 16; r++) wr(16 + r, pat(b * 16 + r), "R12");
        end
        wr(4, 0, "R12");
        for (int it = 0; it < 300; it++) begin
            rd(4, "R12"); v = last_rd;
            wr(4, v | 8, "R12");
            wr(0, 0, "R12");
            rd(4, "R12"); v = last_rd;
            wr(4, (v + 1) & 255, "R12");
            if (((v + 1) & 255) == 0) break;
        end
        rd(4, "R12"); chk(last_rd, 0, "R12");
        for (int g = 1; g < 16; g++) begin
            if (g != 4) begin
                rd(g, "R12");
                chk(last_rd, (g >= 8) ? 0 : pat(g), "R12");
            end
        end
        for (int b = 0; b < 16; b++) begin
            wr(4, b << 4, "R12");
            for (int r = 0; r < 16; r++) begin
                rd(16 + r, "R12");
                chk(last_rd, (b != 0 && r >= 8) ? 0 : pat(b * 16 + r), "R12");
            end
        end
        finish_up();
    end
endmodule